// File: doc/BRIEF.md
# Single-Wire Smart-Card UART with Parity Error Signalling

This block is a half-duplex asynchronous transceiver for a single-wire link. The transmit driver and the receive input share one wire, which is pulled up outside the chip. The block therefore only ever pulls the wire low or lets it go. A character is a low start bit, eight data bits sent least significant bit first, an even parity bit and a high stop bit. Bit timing comes from a clock enable `baud_tick` that pulses `OVS` times per bit period. The receiver samples once per bit, in the middle of the bit.

When a received character fails its parity check and the error-output enable is set, the block pulls the wire low from the middle of the stop bit. It keeps the wire low until software reads the receive buffer. That read clears the parity-error flag and releases the wire on the same clock edge.

On transmit, the completion interrupt fires half a bit period after the stop bit ends. In the same cycle the block captures the wire level into a status bit, so software can see whether the far end answered the character with an error signal.

Top module: `sc_line_uart`

## Requirements
- R1: After reset, `line_pull`, `err_en`, `rx_perr`, `rx_full`, `tx_done_irq`, `rx_done_irq`, `tx_busy` and `line_at_done` are all 0.
- R2: A write with `tx_we` while idle starts a frame on that clock edge. The frame is 11 bits, each `OVS` ticks long, in this order: start (line low), D0..D7 with D0 first, even parity (the XOR of the eight data bits), stop (released). `line_pull`=1 means the wire is driven low; 0 means it is released.
- R3: `OVS*11 + OVS/2` ticks after the frame start, `tx_done_irq` pulses for exactly one cycle and `tx_busy` falls. In that same cycle `line_at_done` takes the wire level sampled at that tick.
- R4: A `tx_we` write while `tx_busy`=1 is ignored: the frame in progress is unchanged and no second frame follows.
- R5: The receiver detects a start on the first tick that sees the wire low after a tick that saw it high. It then samples at `OVS/2` ticks and every `OVS` ticks after that. If the wire is high at the start-bit sample, the character is dropped.
- R6: At the stop-bit sample, `rx_data` takes the eight data bits (D0 in bit 0), `rx_full` is set, `rx_done_irq` pulses for one cycle, and `rx_perr` is set when the XOR of the data and parity bits is 1.
- R7: When that character has a parity error and `err_en`=1, `line_pull` goes to 1 on the stop-bit sample edge. It stays 1 until `rx_rd`.
- R8: `rx_rd` clears `rx_perr`, `rx_full` and the error drive on the same clock edge. A character completing on that edge takes priority over the read.
- R9: With `err_en`=0, a parity error sets `rx_perr` but leaves the wire released. `cfg_we` loads `err_en` from `cfg_err_en`.
- R10: The receiver ignores falling edges on the wire while its own transmitter is busy or its error drive is active. A start is recognised only after a tick that sees the wire high outside those windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Clock enable, OVS pulses per bit period |
| cfg_we | input | 1 | Load the error-output enable |
| cfg_err_en | input | 1 | Value for the error-output enable |
| tx_we | input | 1 | Start transmitting `tx_data` |
| tx_data | input | DW | Character to send |
| rx_rd | input | 1 | Receive buffer read strobe |
| line_in | input | 1 | Level of the shared wire |
| line_pull | output | 1 | 1 = drive the wire low, 0 = release |
| err_en | output | 1 | Error-output enable state |
| tx_busy | output | 1 | Transmit frame or guard window in progress |
| tx_done_irq | output | 1 | One-cycle transmit completion request |
| line_at_done | output | 1 | Wire level captured at transmit completion |
| rx_data | output | DW | Receive buffer |
| rx_perr | output | 1 | Parity error flag of the buffered character |
| rx_full | output | 1 | Receive buffer holds an unread character |
| rx_done_irq | output | 1 | One-cycle receive completion request |

## Verification
The bench sets `OVS` to 4 and pulses `baud_tick` every third clock. A whole character then takes 132 clocks, and the transmit guard window is two ticks long. This makes the glitch rejection case, the error drive held across several bit times, the answer from the card during the guard window, and a write during transmission all short. At that size, the reference model can be checked against every output on every clock.

// File: rtl/sc_line_pkg.sv
package sc_line_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_GUARD} tx_state_e;
  typedef enum logic {RX_IDLE, RX_BUSY} rx_state_e;
endpackage

// File: rtl/sc_line_tx.sv
module sc_line_tx
  import sc_line_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          we,
  input  logic [DW-1:0] data,
  input  logic          line_in,
  output logic          busy,
  output logic          low,
  output logic          done_irq,
  output logic          done_level
);
  localparam int NB   = DW + 3;
  localparam int HALF = OVS / 2;
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(NB);

  tx_state_e      state_q;
  logic [NB-1:0]  frame_q;
  logic [BW-1:0]  bit_q;
  logic [CW-1:0]  tcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= TX_IDLE;
      frame_q    <= '1;
      bit_q      <= '0;
      tcnt_q     <= '0;
      busy       <= 1'b0;
      low        <= 1'b0;
      done_irq   <= 1'b0;
      done_level <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      case (state_q)
        TX_IDLE: begin
          if (we) begin
            frame_q <= {1'b1, ^data, data, 1'b0};
            low     <= 1'b1;
            bit_q   <= '0;
            tcnt_q  <= '0;
            busy    <= 1'b1;
            state_q <= TX_SEND;
          end
        end
        TX_SEND: begin
          if (tick) begin
            if (tcnt_q == CW'(OVS - 1)) begin
              tcnt_q <= '0;
              if (bit_q == BW'(NB - 1)) begin
                low     <= 1'b0;
                state_q <= TX_GUARD;
              end else begin
                bit_q   <= bit_q + 1'b1;
                low     <= ~frame_q[1];
                frame_q <= {1'b1, frame_q[NB-1:1]};
              end
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (tcnt_q == CW'(HALF - 1)) begin
              done_irq   <= 1'b1;
              done_level <= line_in;
              busy       <= 1'b0;
              state_q    <= TX_IDLE;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R2: the driver may pull low only inside a frame
  a_r2_low_only_busy: assert property (@(posedge clk) disable iff (rst)
    low |-> busy);
  // R3: completion request is a single-cycle pulse
  a_r3_irq_single: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);
  // R3: busy has dropped when the request is raised
  a_r3_irq_idle: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> !busy);
  // R4: a write during a frame leaves the frame untouched
  a_r4_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    (busy && we && state_q == TX_GUARD) |=> $stable(frame_q));
endmodule

// File: rtl/sc_line_rx.sv
module sc_line_rx
  import sc_line_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          line_in,
  input  logic          gate,
  output logic          fin,
  output logic          fin_bad,
  output logic [DW-1:0] data
);
  localparam int HALF     = OVS / 2;
  localparam int CW       = $clog2(OVS);
  localparam int BW       = $clog2(DW + 3);
  localparam int PAR_IDX  = DW + 1;
  localparam int STOP_IDX = DW + 2;

  rx_state_e      state_q;
  logic           prev_q;
  logic [CW-1:0]  tcnt_q;
  logic [BW-1:0]  bit_q;
  logic [DW-1:0]  sh_q;
  logic           par_q;
  logic [CW-1:0]  last;
  logic           samp;

  assign last    = (bit_q == '0) ? CW'(HALF - 1) : CW'(OVS - 1);
  assign samp    = (state_q == RX_BUSY) && tick && (tcnt_q == last);
  assign fin     = samp && (bit_q == BW'(STOP_IDX));
  assign fin_bad = ^{sh_q, par_q};
  assign data    = sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_IDLE;
      prev_q  <= 1'b0;
      tcnt_q  <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
    end else if (tick) begin
      if (state_q == RX_IDLE) begin
        prev_q <= gate ? 1'b0 : line_in;
        if (!gate && prev_q && !line_in) begin
          state_q <= RX_BUSY;
          tcnt_q  <= '0;
          bit_q   <= '0;
        end
      end else if (samp) begin
        tcnt_q <= '0;
        bit_q  <= bit_q + 1'b1;
        if (bit_q == '0) begin
          if (line_in) begin
            state_q <= RX_IDLE;
            prev_q  <= line_in;
          end
        end else if (bit_q == BW'(PAR_IDX)) begin
          par_q <= line_in;
        end else if (bit_q == BW'(STOP_IDX)) begin
          state_q <= RX_IDLE;
          prev_q  <= line_in;
        end else begin
          sh_q <= {line_in, sh_q[DW-1:1]};
        end
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  // R10: no start is accepted while the wire is owned locally
  a_r10_gate_blocks: assert property (@(posedge clk) disable iff (rst)
    (state_q == RX_IDLE && gate) |=> state_q == RX_IDLE);
endmodule

// File: rtl/sc_line_uart.sv
module sc_line_uart #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          baud_tick,
  input  logic          cfg_we,
  input  logic          cfg_err_en,
  input  logic          tx_we,
  input  logic [DW-1:0] tx_data,
  input  logic          rx_rd,
  input  logic          line_in,
  output logic          line_pull,
  output logic          err_en,
  output logic          tx_busy,
  output logic          tx_done_irq,
  output logic          line_at_done,
  output logic [DW-1:0] rx_data,
  output logic          rx_perr,
  output logic          rx_full,
  output logic          rx_done_irq
);
  logic          tx_low;
  logic          fin;
  logic          fin_bad;
  logic [DW-1:0] rx_word;
  logic          err_pull_q;
  logic          err_en_q;

  sc_line_tx #(.OVS(OVS), .DW(DW)) u_tx (
    .clk(clk), .rst(rst), .tick(baud_tick), .we(tx_we), .data(tx_data),
    .line_in(line_in), .busy(tx_busy), .low(tx_low),
    .done_irq(tx_done_irq), .done_level(line_at_done)
  );

  sc_line_rx #(.OVS(OVS), .DW(DW)) u_rx (
    .clk(clk), .rst(rst), .tick(baud_tick), .line_in(line_in),
    .gate(tx_busy | err_pull_q), .fin(fin), .fin_bad(fin_bad), .data(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_en_q    <= 1'b0;
      err_pull_q  <= 1'b0;
      rx_perr     <= 1'b0;
      rx_full     <= 1'b0;
      rx_data     <= '0;
      rx_done_irq <= 1'b0;
    end else begin
      rx_done_irq <= fin;
      if (cfg_we) err_en_q <= cfg_err_en;
      if (fin) begin
        rx_data    <= rx_word;
        rx_full    <= 1'b1;
        rx_perr    <= fin_bad;
        err_pull_q <= fin_bad & err_en_q;
      end else if (rx_rd) begin
        rx_full    <= 1'b0;
        rx_perr    <= 1'b0;
        err_pull_q <= 1'b0;
      end
    end
  end

  assign err_en    = err_en_q;
  assign line_pull = tx_low | err_pull_q;

  // R7: error drive persists until the buffer is read
  a_r7_pull_hold: assert property (@(posedge clk) disable iff (rst)
    (err_pull_q && !rx_rd) |=> err_pull_q);
  // R8: a read with no new character clears flags and drive together
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && !fin) |=> (!err_pull_q && !rx_perr && !rx_full));
  // R9: the drive only starts when the enable was set
  a_r9_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(err_pull_q) |-> $past(err_en_q));
  // R6: a parity flag always belongs to a buffered character
  a_r6_perr_with_full: assert property (@(posedge clk) disable iff (rst)
    rx_perr |-> rx_full);
endmodule

// File: tb/sc_line_uart_bench.sv
module sc_line_uart_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OVS  = 4;
  localparam int HALF = OVS / 2;
  localparam int DW   = 8;
  localparam int NB   = 11;
  localparam int TDIV = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic baud_tick = 1'b0;
  logic cfg_we = 1'b0, cfg_err_en = 1'b0, tx_we = 1'b0, rx_rd = 1'b0;
  logic card_low = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic line_pull, err_en, tx_busy, tx_done_irq, line_at_done;
  logic rx_perr, rx_full, rx_done_irq;
  logic [DW-1:0] rx_data;
  wire line_in = !(line_pull | card_low);

  int n_checks = 0, n_fail = 0;
  int tx_irq_cnt = 0, rx_irq_cnt = 0;
  bit finished = 0;

  sc_line_uart #(.OVS(OVS), .DW(DW)) u_sc_line_uart (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .cfg_we(cfg_we),
    .cfg_err_en(cfg_err_en), .tx_we(tx_we), .tx_data(tx_data), .rx_rd(rx_rd),
    .line_in(line_in), .line_pull(line_pull), .err_en(err_en),
    .tx_busy(tx_busy), .tx_done_irq(tx_done_irq), .line_at_done(line_at_done),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_full(rx_full),
    .rx_done_irq(rx_done_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int dcnt = 0;
  always @(negedge clk) begin
    if (dcnt == TDIV - 1) begin dcnt <= 0; baud_tick <= 1'b1; end
    else begin dcnt <= dcnt + 1; baud_tick <= 1'b0; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model: tick counts since events, updated at each rising edge
  int m_tx_t = -1, m_rx_t = -1;
  bit m_prev = 0;
  logic [NB-1:0] m_frame = '1;
  logic [DW-1:0] m_sh = '0;
  bit m_par = 0;
  bit e_tx_low = 0, e_pull_err = 0, e_busy = 0, e_irq = 0, e_lvl = 0;
  bit e_perr = 0, e_full = 0, e_rxirq = 0, e_en = 0;
  logic [DW-1:0] e_data = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_tx_t = -1; m_rx_t = -1; m_prev = 0;
      e_tx_low = 0; e_pull_err = 0; e_busy = 0; e_irq = 0; e_lvl = 0;
      e_perr = 0; e_full = 0; e_rxirq = 0; e_en = 0; e_data = '0;
    end else begin
      bit s, gate, en_old;
      s = line_in; gate = e_busy | e_pull_err; en_old = e_en;
      e_irq = 0; e_rxirq = 0;
      if (rx_rd) begin e_full = 0; e_perr = 0; e_pull_err = 0; end
      if (cfg_we) e_en = cfg_err_en;
      if (m_tx_t < 0) begin
        if (tx_we) begin
          m_frame = {1'b1, ^tx_data, tx_data, 1'b0};
          m_tx_t = 0; e_busy = 1; e_tx_low = 1;
        end
      end else if (baud_tick) begin
        m_tx_t++;
        if (m_tx_t == NB*OVS + HALF) begin
          e_irq = 1; e_lvl = s; e_busy = 0; e_tx_low = 0; m_tx_t = -1;
        end else begin
          e_tx_low = (m_tx_t < NB*OVS) ? !m_frame[m_tx_t/OVS] : 1'b0;
        end
      end
      if (baud_tick) begin
        if (m_rx_t < 0) begin
          if (!gate && m_prev && !s) m_rx_t = 0;
          m_prev = gate ? 1'b0 : s;
        end else begin
          m_rx_t++;
          if (m_rx_t >= HALF && (m_rx_t - HALF) % OVS == 0) begin
            int k;
            k = (m_rx_t - HALF) / OVS;
            if (k == 0) begin
              if (s) begin m_rx_t = -1; m_prev = s; end
            end else if (k <= DW) m_sh[k-1] = s;
            else if (k == DW + 1) m_par = s;
            else begin
              e_data = m_sh; e_full = 1; e_perr = ^{m_sh, m_par};
              e_pull_err = e_perr & en_old; e_rxirq = 1;
              m_rx_t = -1; m_prev = s;
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(line_pull == (e_tx_low | e_pull_err), "R2/R7 line_pull", line_pull, e_tx_low | e_pull_err);
      chk(tx_busy == e_busy, "R4 tx_busy", tx_busy, e_busy);
      chk(tx_done_irq == e_irq, "R3 tx_done_irq", tx_done_irq, e_irq);
      chk(line_at_done == e_lvl, "R3 line_at_done", line_at_done, e_lvl);
      chk(rx_data == e_data, "R6 rx_data", rx_data, e_data);
      chk(rx_perr == e_perr, "R6 rx_perr", rx_perr, e_perr);
      chk(rx_full == e_full, "R8 rx_full", rx_full, e_full);
      chk(rx_done_irq == e_rxirq, "R5 rx_done_irq", rx_done_irq, e_rxirq);
      chk(err_en == e_en, "R9 err_en", err_en, e_en);
      if (tx_done_irq) tx_irq_cnt++;
      if (rx_done_irq) rx_irq_cnt++;
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n) begin
      do @(posedge clk); while (!baud_tick);
    end
    @(negedge clk);
  endtask

  task automatic pulse_rd();
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic set_en(input bit v);
    cfg_err_en = v; cfg_we = 1'b1; @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic card_send(input logic [DW-1:0] d, input bit bad);
    logic [NB-1:0] f;
    f = {1'b1, ^d ^ bad, d, 1'b0};
    for (int b = 0; b < NB; b++) begin
      card_low = !f[b];
      wait_ticks(OVS);
    end
    card_low = 1'b0;
  endtask

  task automatic start_tx(input logic [DW-1:0] d);
    tx_data = d; tx_we = 1'b1; @(negedge clk); tx_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] f;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(line_pull == 0 && err_en == 0 && rx_perr == 0 && rx_full == 0, "R1 reset flags",
        {line_pull, err_en, rx_perr, rx_full}, 0);
    chk(tx_busy == 0 && tx_done_irq == 0 && rx_done_irq == 0 && line_at_done == 0,
        "R1 reset tx", {tx_busy, tx_done_irq, rx_done_irq, line_at_done}, 0);
    wait_ticks(3);

    // R6 good character
    card_send(8'hA5, 0);
    wait_ticks(2);
    chk(rx_full == 1 && rx_perr == 0, "R6 good char flags", {rx_full, rx_perr}, 2'b10);
    chk(rx_data == 8'hA5, "R6 good char data", rx_data, 8'hA5);
    pulse_rd();

    // R7 error drive with enable set, held until read
    set_en(1);
    card_send(8'h3C, 1);
    chk(line_pull == 1 && rx_perr == 1, "R7 error drive", {line_pull, rx_perr}, 2'b11);
    wait_ticks(3*OVS);
    chk(line_pull == 1, "R7 drive held", line_pull, 1);
    chk(rx_irq_cnt == 2, "R10 no start from own drive", rx_irq_cnt, 2);
    pulse_rd();
    chk(line_pull == 0 && rx_perr == 0 && rx_full == 0, "R8 read clears",
        {line_pull, rx_perr, rx_full}, 0);
    wait_ticks(4*OVS);
    chk(rx_irq_cnt == 2 && rx_full == 0, "R10 no start after release", rx_irq_cnt, 2);

    // R9 enable off: flag only
    set_en(0);
    card_send(8'h81, 1);
    chk(rx_perr == 1 && line_pull == 0, "R9 flag without drive", {rx_perr, line_pull}, 2'b10);
    chk(rx_data == 8'h81, "R6 data 81", rx_data, 8'h81);
    pulse_rd();

    // R5 glitch shorter than half a bit is dropped
    wait_ticks(2);
    card_low = 1'b1; wait_ticks(1); card_low = 1'b0;
    wait_ticks(14*OVS);
    chk(rx_irq_cnt == 3 && rx_full == 0, "R5 false start dropped", rx_irq_cnt, 3);

    // R2 transmit frame sampled mid-bit, R4 write during frame
    start_tx(8'h5A);
    f = {1'b1, ^8'h5A, 8'h5A, 1'b0};
    wait_ticks(HALF);
    for (int b = 0; b < NB; b++) begin
      chk(line_pull == !f[b], "R2 tx bit", line_pull, !f[b]);
      if (b == 5) start_tx(8'hFF);
      wait_ticks(OVS);
    end
    wait_ticks(2);
    chk(tx_busy == 0 && tx_irq_cnt == 1, "R3 tx complete", {tx_busy, 8'(tx_irq_cnt)}, 1);
    chk(line_at_done == 1, "R3 no card error", line_at_done, 1);
    wait_ticks(2*OVS);
    chk(line_pull == 0 && tx_busy == 0 && tx_irq_cnt == 1, "R4 write ignored",
        {line_pull, tx_busy, 8'(tx_irq_cnt)}, 1);
    chk(rx_irq_cnt == 3, "R10 own tx not received", rx_irq_cnt, 3);

    // R3 card answers with an error during the guard window
    start_tx(8'h00);
    wait_ticks(10*OVS + HALF);
    card_low = 1'b1;
    wait_ticks(2*OVS);
    card_low = 1'b0;
    wait_ticks(OVS);
    chk(line_at_done == 0 && tx_irq_cnt == 2, "R3 card error seen",
        {line_at_done, 8'(tx_irq_cnt)}, 2);
    chk(rx_irq_cnt == 3, "R10 card answer not received", rx_irq_cnt, 3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule